// File: doc/BRIEF.md
# Exception Vectoring and Fault Escalation Unit

This unit turns an exception request into a handler entry. A request carries an 8-bit vector, an error code word, the return instruction pointer, the flags word and the current stack pointer. The unit holds a descriptor table base and byte limit, which software loads with a single command. It reads the 16-byte gate descriptor for the vector as two 64-bit beats over a read port with a valid/ready handshake. It then checks that the entry can be used, pushes the return state onto the stack through a 64-bit write port, and presents the handler address, the code selector, the new flags word and the final stack pointer as a one-cycle delivery pulse.

An entry can be unusable for four reasons: it lies beyond the table limit, it is marked absent, its fixed option bits are wrong, or one of its reads returns an error. In that case the unit gives up on the original vector and delivers a double fault on vector 8 with an error code of zero. If the double-fault delivery fails as well, the unit stops and raises a sticky reset request. The stack index and privilege level are only reported; enforcing them is left to the surrounding core.

Top module: `exc_vector_unit`

## Requirements
- R1: When `tbl_load` is high at a clock edge, `tbl_base` and `tbl_limit` are captured. After reset both are zero, so every vector is out of range and the first request ends in a triple fault.
- R2: The entry for vector v is read as two beats, at base+16·v and then base+16·v+8. `rd_valid` and `rd_addr` are held until `rd_ready` is seen. Each response is taken on `rsp_valid`.
- R3: Beat 0 holds handler bits 15:0 in bits 15:0, the selector in bits 31:16, the options word in bits 47:32 and handler bits 31:16 in bits 63:48. Beat 1 bits 31:0 hold handler bits 63:32. In the options word, bits 2:0 are the stack index and bits 14:13 are the privilege level; both are reported on delivery.
- R4: An entry whose last byte (16·v+15) is greater than the limit is unusable, and no read is issued for it.
- R5: An entry is usable only when options bit 15 (present) is 1, bits 11:9 are 111 and bit 12 is 0.
- R6: In normal state, an unusable entry or a read error on the entry starts a double fault. The unit refetches vector 8, delivers with `dlv_vector`=8 and pushes an error code of zero.
- R7: When the double-fault delivery fails, `reset_req` rises and stays high until `rst`. The unit then issues no read and no push, and `req_ready` stays low.
- R8: The unit pushes the return pointer, then the flags, then the error code. The error code is pushed only for vectors 8, 10, 11, 12, 13, 14, 17, 21, 29 and 30. Write k (counting from 1) goes to sp−8·k. Push address and data are held until `push_ready`.
- R9: `dlv_flags` is the request flags with bit 9 cleared when options bit 8 is 0 (interrupt gate). When options bit 8 is 1 (trap gate), the flags are passed unchanged.
- R10: `dlv_valid` is a single-cycle pulse in the cycle after the last push is accepted. It carries the handler, selector, stack index, privilege level, flags and the address of the last push. After it, the escalation level is normal again.
- R11: `req_ready` is high only while the unit is idle. A request is taken when `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_load | input | 1 | Load table base and limit |
| tbl_base | input | 64 | Table base address |
| tbl_limit | input | LIM_W | Table size in bytes minus one |
| req_valid | input | 1 | Exception request present |
| req_ready | output | 1 | Unit idle, request accepted |
| req_vector | input | 8 | Exception vector |
| req_err_code | input | 64 | Error code for vectors that carry one |
| req_rip | input | 64 | Return instruction pointer |
| req_flags | input | 64 | Flags word at the fault |
| req_sp | input | 64 | Stack pointer before pushes |
| rd_valid | output | 1 | Read request |
| rd_ready | input | 1 | Read request taken |
| rd_addr | output | 64 | Read address |
| rsp_valid | input | 1 | Read data present |
| rsp_err | input | 1 | Read error response |
| rsp_data | input | 64 | Read data |
| push_valid | output | 1 | Stack write request |
| push_ready | input | 1 | Stack write taken |
| push_addr | output | 64 | Stack write address |
| push_data | output | 64 | Stack write data |
| dlv_valid | output | 1 | Handler entry pulse |
| dlv_vector | output | 8 | Vector actually delivered |
| dlv_handler | output | 64 | Handler address |
| dlv_selector | output | 16 | New code selector |
| dlv_stack_idx | output | 3 | Stack table index (0 = no switch) |
| dlv_dpl | output | 2 | Descriptor privilege level |
| dlv_flags | output | 64 | Flags after entry |
| dlv_sp | output | 64 | Stack pointer after pushes |
| reset_req | output | 1 | Triple fault, reset needed |

## Verification
The hardest case to reach is a failure during the second delivery. Here the vector-8 entry itself must be unusable, or its read must return an error, and this must happen after a first fault has already raised the escalation level. The bench keeps a descriptor memory model with a separate kind for each vector and an optional read-error target. Directed cases make vector 8 absent and, in a separate case, make its read fail. Random runs then mix absent, malformed, out-of-range and faulting entries, and the bench resets and reloads the table after every predicted triple fault. The exact limit boundary, one byte short and one byte sufficient, is also driven directly.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int WORD = 64;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_RD0, S_W0, S_RD1, S_W1, S_CHECK, S_PUSH, S_HALT
  } exc_state_t;

  typedef struct packed {
    logic [WORD-1:0] handler;
    logic [15:0]     selector;
    logic [2:0]      stack_idx;
    logic [1:0]      dpl;
    logic            trap;
    logic            usable;
  } gate_t;

  // vectors that place an error code on the stack (R8)
  function automatic logic carries_code(input logic [7:0] v);
    case (v)
      8'd8, 8'd10, 8'd11, 8'd12, 8'd13, 8'd14,
      8'd17, 8'd21, 8'd29, 8'd30: carries_code = 1'b1;
      default:                    carries_code = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/exc_gate_decode.sv
module exc_gate_decode
  import exc_pkg::*;
(
  input  logic [WORD-1:0] beat_lo,
  input  logic [31:0]     beat_hi,
  output gate_t           gate
);
  logic [15:0] opts;
  logic        unused_rsvd;

  assign opts = beat_lo[47:32];

  // R3: pointer pieces rejoined from three places
  assign gate.handler   = {beat_hi, beat_lo[63:48], beat_lo[15:0]};
  assign gate.selector  = beat_lo[31:16];
  assign gate.stack_idx = opts[2:0];
  assign gate.dpl       = opts[14:13];
  assign gate.trap      = opts[8];
  // R5: present, fixed ones and fixed zero
  assign gate.usable    = opts[15] & (&opts[11:9]) & ~opts[12];
  assign unused_rsvd    = ^opts[7:3];
endmodule

// File: rtl/exc_push_seq.sv
module exc_push_seq
  import exc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [WORD-1:0] sp_in,
  input  logic [WORD-1:0] word0,
  input  logic [WORD-1:0] word1,
  input  logic [WORD-1:0] word2,
  input  logic            three,
  output logic            push_valid,
  input  logic            push_ready,
  output logic [WORD-1:0] push_addr,
  output logic [WORD-1:0] push_data,
  output logic            done
);
  logic       active_q;
  logic [1:0] idx_q;
  logic       last;

  assign last       = (idx_q == (three ? 2'd2 : 2'd1));
  assign push_valid = active_q;
  assign done       = active_q & push_ready & last;

  always_comb begin
    case (idx_q)
      2'd0:    push_data = word0;
      2'd1:    push_data = word1;
      default: push_data = word2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      idx_q     <= 2'd0;
      push_addr <= '0;
    end else if (start) begin
      active_q  <= 1'b1;
      idx_q     <= 2'd0;
      push_addr <= sp_in - WORD'(8);
    end else if (active_q && push_ready) begin
      if (last) begin
        active_q <= 1'b0;
      end else begin
        idx_q     <= idx_q + 2'd1;
        push_addr <= push_addr - WORD'(8);
      end
    end
  end

  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (rst)
    push_valid && !push_ready |=> push_valid && $stable(push_addr) && $stable(push_data)); // R8
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
    push_valid && push_ready && !last |=> push_valid && (push_addr == $past(push_addr) - WORD'(8))); // R8
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_pkg::*;
#(
  parameter int LIM_W  = 16,
  parameter int IF_BIT = 9,
  parameter int DF_VEC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tbl_load,
  input  logic [WORD-1:0]  tbl_base,
  input  logic [LIM_W-1:0] tbl_limit,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_vector,
  input  logic [WORD-1:0]  req_err_code,
  input  logic [WORD-1:0]  req_rip,
  input  logic [WORD-1:0]  req_flags,
  input  logic [WORD-1:0]  req_sp,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [WORD-1:0]  rd_addr,
  input  logic             rsp_valid,
  input  logic             rsp_err,
  input  logic [WORD-1:0]  rsp_data,
  output logic             push_valid,
  input  logic             push_ready,
  output logic [WORD-1:0]  push_addr,
  output logic [WORD-1:0]  push_data,
  output logic             dlv_valid,
  output logic [7:0]       dlv_vector,
  output logic [WORD-1:0]  dlv_handler,
  output logic [15:0]      dlv_selector,
  output logic [2:0]       dlv_stack_idx,
  output logic [1:0]       dlv_dpl,
  output logic [WORD-1:0]  dlv_flags,
  output logic [WORD-1:0]  dlv_sp,
  output logic             reset_req
);
  localparam int OFF_W = 12;
  localparam logic [WORD-1:0] IF_MASK = WORD'(1) << IF_BIT;

  exc_state_t       state_q;
  logic [WORD-1:0]  base_q;
  logic [LIM_W-1:0] lim_q;
  logic             lvl_q;
  logic [7:0]       vec_q;
  logic [WORD-1:0]  rip_q, flg_q, sp_q, err_q, addr_q;
  logic [WORD-1:0]  beat0_q;
  logic [31:0]      beat1_q;
  logic [OFF_W-1:0] entry_off, entry_end;
  logic             beyond, fault, seq_start, seq_done;
  gate_t            gate;

  assign entry_off = {vec_q, 4'h0};
  assign entry_end = entry_off + OFF_W'(15);
  assign beyond    = 32'(entry_end) > 32'(lim_q);              // R4

  assign req_ready = (state_q == S_IDLE);                      // R11
  assign rd_valid  = (state_q == S_RD0) || (state_q == S_RD1);
  assign rd_addr   = addr_q;

  assign fault = ((state_q == S_START) && beyond) ||
                 (((state_q == S_W0) || (state_q == S_W1)) && rsp_valid && rsp_err) ||
                 ((state_q == S_CHECK) && !gate.usable);
  assign seq_start = (state_q == S_CHECK) && gate.usable;

  exc_gate_decode u_dec (.beat_lo(beat0_q), .beat_hi(beat1_q), .gate(gate));

  exc_push_seq u_push (
    .clk(clk), .rst(rst), .start(seq_start), .sp_in(sp_q),
    .word0(rip_q), .word1(flg_q), .word2(err_q), .three(carries_code(vec_q)),
    .push_valid(push_valid), .push_ready(push_ready),
    .push_addr(push_addr), .push_data(push_data), .done(seq_done)
  );

  // R1: table registers
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      lim_q  <= '0;
    end else if (tbl_load) begin
      base_q <= tbl_base;
      lim_q  <= tbl_limit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      lvl_q <= 1'b0; vec_q <= '0; rip_q <= '0; flg_q <= '0; sp_q <= '0;
      err_q <= '0; addr_q <= '0; beat0_q <= '0; beat1_q <= '0;
      dlv_valid <= 1'b0; dlv_vector <= '0; dlv_handler <= '0; dlv_selector <= '0;
      dlv_stack_idx <= '0; dlv_dpl <= '0; dlv_flags <= '0; dlv_sp <= '0;
      reset_req <= 1'b0;
    end else begin
      dlv_valid <= 1'b0;
      if (fault) begin
        if (lvl_q) begin                                        // R7
          reset_req <= 1'b1;
          state_q   <= S_HALT;
        end else begin                                          // R6
          lvl_q   <= 1'b1;
          vec_q   <= 8'(DF_VEC);
          err_q   <= '0;
          state_q <= S_START;
        end
      end else begin
        case (state_q)
          S_IDLE: if (req_valid) begin
            lvl_q <= 1'b0; vec_q <= req_vector; rip_q <= req_rip;
            flg_q <= req_flags; sp_q <= req_sp; err_q <= req_err_code;
            state_q <= S_START;
          end
          S_START: begin                                        // R2
            addr_q  <= base_q + WORD'(entry_off);
            state_q <= S_RD0;
          end
          S_RD0: if (rd_ready) state_q <= S_W0;
          S_W0: if (rsp_valid) begin
            beat0_q <= rsp_data;
            addr_q  <= addr_q + WORD'(8);
            state_q <= S_RD1;
          end
          S_RD1: if (rd_ready) state_q <= S_W1;
          S_W1: if (rsp_valid) begin
            beat1_q <= rsp_data[31:0];
            state_q <= S_CHECK;
          end
          S_CHECK: state_q <= S_PUSH;
          S_PUSH: if (seq_done) begin                           // R10
            dlv_valid     <= 1'b1;
            dlv_vector    <= vec_q;
            dlv_handler   <= gate.handler;
            dlv_selector  <= gate.selector;
            dlv_stack_idx <= gate.stack_idx;
            dlv_dpl       <= gate.dpl;
            dlv_flags     <= gate.trap ? flg_q : (flg_q & ~IF_MASK); // R9
            dlv_sp        <= push_addr;
            lvl_q         <= 1'b0;
            state_q       <= S_IDLE;
          end
          default: state_q <= state_q;
        endcase
      end
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R2
  AST_TRIPLE_STICKY: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> reset_req); // R7
  AST_TRIPLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> !rd_valid && !push_valid && !req_ready && !dlv_valid); // R7
  AST_DLV_PULSE: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |=> !dlv_valid); // R10
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && push_valid)); // R8
  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready); // R11
endmodule

// File: tb/sim_exc_vector_unit.sv
`timescale 1ns/1ps
module sim_exc_vector_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic tbl_load = 0; logic [63:0] tbl_base = 0; logic [15:0] tbl_limit = 0;
  logic req_valid = 0; logic req_ready; logic [7:0] req_vector = 0;
  logic [63:0] req_err_code = 0, req_rip = 0, req_flags = 0, req_sp = 0;
  logic rd_valid; logic rd_ready = 0; logic [63:0] rd_addr;
  logic rsp_valid = 0; logic rsp_err = 0; logic [63:0] rsp_data = 0;
  logic push_valid; logic push_ready = 0; logic [63:0] push_addr, push_data;
  logic dlv_valid; logic [7:0] dlv_vector; logic [63:0] dlv_handler;
  logic [15:0] dlv_selector; logic [2:0] dlv_stack_idx; logic [1:0] dlv_dpl;
  logic [63:0] dlv_flags, dlv_sp; logic reset_req;

  exc_vector_unit u0 (.*);

  int nchk = 0, nerr = 0;
  int kind [0:255];          // 0 interrupt gate, 1 trap gate, 2 absent, 3 bad fixed bit
  logic [63:0] hnd [0:255];
  logic [15:0] sel [0:255];
  logic [2:0]  ist [0:255];
  logic [1:0]  dpl [0:255];
  int err_vec = -1;
  logic [63:0] tb_base = 0;
  int tb_lim = 0;

  int np, nrd; bit got_dlv; bit pend = 0; logic [63:0] pend_addr;
  logic [63:0] pa [0:7]; logic [63:0] pd [0:7];
  logic [7:0] c_vec; logic [63:0] c_hnd, c_flags, c_sp; logic [15:0] c_sel;
  logic [2:0] c_ist; logic [1:0] c_dpl;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit has_code(input int v);
    return (v == 8 || v == 10 || v == 11 || v == 12 || v == 13 || v == 14 ||
            v == 17 || v == 21 || v == 29 || v == 30);
  endfunction

  function automatic logic [15:0] opts_of(input int v);
    return {kind[v] != 2, dpl[v], kind[v] == 3, 3'b111, kind[v] == 1, 5'b0, ist[v]};
  endfunction

  function automatic logic [63:0] mem_word(input logic [63:0] a);
    logic [63:0] off; int v;
    off = a - tb_base;
    v = int'(off[11:4]);
    if (!off[3]) return {hnd[v][31:16], opts_of(v), sel[v], hnd[v][15:0]};
    return {32'hA5A5_0000, hnd[v][63:32]};
  endfunction

  always @(posedge clk) begin
    if (rd_valid && rd_ready) begin nrd++; pend = 1; pend_addr = rd_addr; end
    if (push_valid && push_ready && np < 8) begin pa[np] = push_addr; pd[np] = push_data; np++; end
    if (dlv_valid) begin
      got_dlv = 1; c_vec = dlv_vector; c_hnd = dlv_handler; c_sel = dlv_selector;
      c_ist = dlv_stack_idx; c_dpl = dlv_dpl; c_flags = dlv_flags; c_sp = dlv_sp;
    end
  end

  always @(negedge clk) begin
    if (pend) begin
      rsp_valid = 1; rsp_data = mem_word(pend_addr);
      rsp_err = (err_vec >= 0) && (int'((pend_addr - tb_base) >> 4) == err_vec);
      pend = 0;
    end else begin
      rsp_valid = 0; rsp_err = 0;
    end
    rd_ready   = ($urandom % 4) != 0;
    push_ready = ($urandom % 3) != 0;
  end

  task automatic do_reset();
    @(negedge clk); rst = 1; req_valid = 0; tbl_load = 0;
    repeat (3) @(negedge clk);
    rst = 0; tb_base = 0; tb_lim = 0;
  endtask

  task automatic load_tbl(input logic [63:0] b, input int lim);
    @(negedge clk); tbl_load = 1; tbl_base = b; tbl_limit = 16'(lim);
    @(negedge clk); tbl_load = 0;
    tb_base = b; tb_lim = lim;
  endtask

  // returns 1 when a triple fault was predicted
  task automatic do_req(input int vec, input logic [63:0] rip, input logic [63:0] flg,
                        input logic [63:0] sp, input logic [63:0] ec, output bit tripled);
    int lvl, v, reads, ev, n; bit bad, esc, deliver;
    lvl = 0; v = vec; reads = 0; esc = 0; deliver = 0;
    forever begin
      if (16 * v + 15 > tb_lim) bad = 1;
      else if (err_vec == v) begin reads += 1; bad = 1; end
      else begin reads += 2; bad = (kind[v] >= 2); end
      if (!bad) begin deliver = 1; break; end
      if (lvl == 0) begin lvl = 1; v = 8; esc = 1; end
      else break;
    end
    ev = v;
    np = 0; nrd = 0; got_dlv = 0;
    @(negedge clk);
    req_vector = 8'(vec); req_rip = rip; req_flags = flg; req_sp = sp; req_err_code = ec;
    req_valid = 1;
    do @(posedge clk); while (!req_ready);
    @(negedge clk); req_valid = 0;
    chk(req_ready == 0, "R11 busy after accept", 64'(req_ready), 0);
    for (int c = 0; c < 3000 && !got_dlv && !reset_req; c++) @(negedge clk);
    chk(nrd == reads, "R2/R4 read count", 64'(nrd), 64'(reads));
    tripled = !deliver;
    if (deliver) begin
      chk(got_dlv, "R10 delivery pulse", 64'(got_dlv), 1);
      chk(c_vec == 8'(ev), esc ? "R6 double fault vector" : "R10 vector", 64'(c_vec), 64'(ev));
      chk(c_hnd == hnd[ev], "R3 handler", c_hnd, hnd[ev]);
      chk(c_sel == sel[ev] && c_ist == ist[ev] && c_dpl == dpl[ev], "R3 selector/index/level",
          {c_sel, 13'b0, c_ist, 6'b0, c_dpl}, {sel[ev], 13'b0, ist[ev], 6'b0, dpl[ev]});
      chk(c_flags == (kind[ev] == 1 ? flg : (flg & ~64'h200)), "R9 flags", c_flags,
          kind[ev] == 1 ? flg : (flg & ~64'h200));
      n = has_code(ev) ? 3 : 2;
      chk(np == n, "R8 push count", 64'(np), 64'(n));
      for (int i = 0; i < n && i < np; i++) begin
        logic [63:0] ed;
        ed = (i == 0) ? rip : (i == 1) ? flg : (esc ? 64'd0 : ec);
        chk(pa[i] == sp - 64'(8 * (i + 1)), "R8 push address", pa[i], sp - 64'(8 * (i + 1)));
        chk(pd[i] == ed, esc && i == 2 ? "R6 zero error code" : "R8 push data", pd[i], ed);
      end
      chk(c_sp == sp - 64'(8 * n), "R10 final stack pointer", c_sp, sp - 64'(8 * n));
      @(negedge clk);
      chk(dlv_valid == 0 && req_ready == 1, "R10 pulse ends, idle", {dlv_valid, req_ready}, 1);
    end else begin
      chk(reset_req == 1 && got_dlv == 0, "R7 triple fault", {reset_req, got_dlv}, 2);
      np = 0;
      repeat (6) @(negedge clk);
      chk(reset_req == 1 && req_ready == 0 && np == 0 && rd_valid == 0, "R7 halted",
          {reset_req, req_ready, rd_valid, 8'(np)}, 64'h400);
    end
  endtask

  task automatic fill(input int v, input int k);
    kind[v] = k; hnd[v] = 64'hFFFF_8000_0000_0000 + 64'(v) * 64'h1234_5679_0BCD;
    sel[v] = 16'h0008 + 16'(v); ist[v] = 3'(v); dpl[v] = 2'(v >> 1);
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin : main
    bit t; int v0;
    void'($urandom(32'd20240611));
    for (int v = 0; v < 256; v++) fill(v, 2);
    do_reset();
    @(negedge clk);
    chk(req_ready == 1 && reset_req == 0 && dlv_valid == 0 && rd_valid == 0 && push_valid == 0,
        "R1 reset state", {req_ready, reset_req, dlv_valid, rd_valid, push_valid}, 64'h10);
    // R1: limit zero after reset, everything is out of range
    do_req(0, 64'h1000, 64'h202, 64'h8000, 0, t);

    do_reset();
    load_tbl(64'h0001_0000, 16 * 32 - 1);
    fill(0, 0); fill(14, 1); fill(6, 2); fill(5, 3); fill(8, 0); fill(31, 0);
    fill(3, 0); fill(32, 0); fill(13, 0);
    kind[5] = 3;
    do_req(0, 64'hAAAA_0000_1111_2222, 64'h246, 64'h9000, 64'd77, t);       // R9 interrupt gate
    do_req(14, 64'h0000_7FFF_0000_1234, 64'h202, 64'h9008, 64'h1B, t);      // R8 code, R9 trap
    do_req(6, 64'h55, 64'h200, 64'hA000, 64'h99, t);                         // R5 absent -> R6
    do_req(5, 64'h66, 64'h3202, 64'hA100, 64'h99, t);                        // R5 bad bit12
    do_req(31, 64'h77, 64'h0, 64'hA200, 64'h0, t);                           // R4 exact fit
    do_req(32, 64'h88, 64'h200, 64'hA300, 64'h0, t);                         // R4 beyond
    load_tbl(64'h0001_0000, 16 * 32 - 2);
    do_req(31, 64'h99, 64'h200, 64'hA400, 64'h0, t);                         // R4 one short
    load_tbl(64'h0001_0000, 16 * 32 - 1);
    err_vec = 3;
    do_req(3, 64'hAB, 64'h200, 64'hA500, 64'h0, t);                          // R6 read error
    err_vec = -1;
    do_req(6, 64'hAC, 64'h200, 64'hA600, 64'h0, t);                          // R10 level cleared
    kind[8] = 2;
    do_req(6, 64'hAD, 64'h200, 64'hA700, 64'h0, t);                          // R7 absent DF
    do_reset(); load_tbl(64'h0001_0000, 16 * 32 - 1); kind[8] = 0;
    err_vec = 8;
    do_req(6, 64'hAE, 64'h200, 64'hA800, 64'h0, t);                          // R7 DF read error
    err_vec = -1;
    do_reset(); load_tbl(64'h0001_0000, 16 * 32 - 1);
    do_req(13, 64'hAF, 64'h202, 64'hA900, 64'h4, t);                         // R8 code vector 13

    // constrained random mix
    do_reset(); load_tbl(64'h4000_0000, 16 * 40 - 1);
    for (int v = 0; v < 48; v++) begin
      int r; r = $urandom % 10;
      fill(v, r < 5 ? 0 : r < 7 ? 1 : r < 9 ? 2 : 3);
      hnd[v] = {$urandom, $urandom}; sel[v] = 16'($urandom);
      ist[v] = 3'($urandom); dpl[v] = 2'($urandom);
    end
    for (int i = 0; i < 60; i++) begin
      v0 = $urandom % 48;
      err_vec = ($urandom % 6 == 0) ? (($urandom % 2) ? v0 : 8) : -1;
      do_req(v0, {$urandom, $urandom}, {$urandom, $urandom},
             {$urandom, $urandom} & ~64'h7, {$urandom, $urandom}, t);
      if (t) begin do_reset(); load_tbl(64'h4000_0000, 16 * 40 - 1); end
    end
    err_vec = -1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule